// File: doc/BRIEF.md
# GF(64) Reed-Solomon Systematic Encoder

This block turns a stream of six-bit message symbols into Reed-Solomon codewords of 63 symbols over the field GF(2^6), built from the primitive polynomial x^6+x+1 with alpha as its root. Message symbols arrive on a valid/ready input. Each accepted symbol is copied unchanged to the output one cycle later. After 55 of them, the block closes the input for eight cycles and emits the eight parity symbols on consecutive cycles. The codeword is then complete and the input opens again.

Parity comes from an eight-stage division register. The generator polynomial is the product of (x + alpha^i) for i from 1 to 8, and its coefficients are fixed when the design is elaborated. Each tap multiplies by a constant through a log/antilog lookup. A product with a zero operand is forced to zero. The exponent sum is reduced modulo 63 before the antilog step, so alpha^63 and alpha^0 are the same element. Two output flags mark the first and the last symbol of each codeword.

Top module: `rs_gf64_encoder`

## Requirements
- R1: The lookup multiplier returns the same product as shift-and-add polynomial multiplication reduced by x^6+x+1 (x^6 = x+1, element bit k is the coefficient of x^k) for every operand pair. Any product with a zero operand is zero.
- R2: Exponents wrap modulo 63. Examples: 0x20*0x02 = 0x03, 0x21*0x02 = 0x01, 0x20*0x20 = 0x30, 0x21*0x21 = 0x31.
- R3: While in_ready_o is high, a symbol accepted with in_valid_i appears on out_data_o with out_valid_o high on the next cycle, unchanged.
- R4: The 8 parity symbols follow the 55th data symbol on the 8 immediately following cycles. in_ready_o is low throughout, so input offered during them is ignored.
- R5: Read the codeword as a polynomial with the first output symbol as the coefficient of x^62. It evaluates to zero at alpha^1 through alpha^8.
- R6: out_sof_o is high only with the first symbol of a codeword, and out_eof_o only with the 63rd. Neither is high without out_valid_o.
- R7: A cycle with in_valid_i low during the data phase produces no output symbol, and the codeword position is kept across the gap.
- R8: Asynchronous reset (rst_ni low) clears any partial codeword. out_valid_o, out_sof_o and out_eof_o are low and in_ready_o is high.
- R9: Changing any single symbol of an emitted codeword gives at least one nonzero syndrome among alpha^1 through alpha^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Message symbol offered |
| in_data_i | input | 6 | Message symbol |
| in_ready_o | output | 1 | Block takes a symbol this cycle (low during parity) |
| out_valid_o | output | 1 | Output symbol present |
| out_data_o | output | 6 | Codeword symbol, data then parity |
| out_sof_o | output | 1 | First symbol of codeword |
| out_eof_o | output | 1 | Last symbol of codeword |

## Verification
The bench builds the encoder with its default parameters: 63 total and 55 data symbols, so eight parity stages. At this size the whole 64-by-64 operand space of the multiplier can be compared against polynomial multiplication, including the zero rows and the exponent wrap. Each emitted codeword is tested at all eight generator roots, and a corrupted copy must fail that test. Codewords are sent with a continuous input and with periodic valid gaps, and one run is broken off by a mid-codeword reset.

// File: rtl/rs_gf_pkg.sv
package rs_gf_pkg;
  localparam int SYM_W     = 6;
  localparam int FIELD_ORD = (1 << SYM_W) - 1;
  localparam logic [SYM_W-1:0] POLY_LOW = 6'h03; // x^6 = x + 1
  localparam int MAX_PAR   = 16;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [SYM_W:0]   exp_sum_t;

  function automatic sym_t gf_xtime(sym_t v);
    return {v[SYM_W-2:0], 1'b0} ^ (v[SYM_W-1] ? POLY_LOW : '0);
  endfunction

  function automatic sym_t gf_apow(int e);
    sym_t v;
    v = sym_t'(1);
    for (int k = 0; k < (e % FIELD_ORD); k++) v = gf_xtime(v);
    return v;
  endfunction

  function automatic sym_t gf_log(sym_t v);
    sym_t p, r;
    p = sym_t'(1);
    r = '0;
    for (int k = 0; k < FIELD_ORD; k++) begin
      if (p == v) r = sym_t'(k);
      p = gf_xtime(p);
    end
    return r;
  endfunction

  // shift-and-add product, used for constants only
  function automatic sym_t gf_pmul(sym_t a, sym_t b);
    sym_t acc, sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // coefficient idx of prod_{i=1..npar} (x + alpha^i)
  function automatic sym_t gen_coef(int npar, int idx);
    sym_t g [MAX_PAR+1];
    sym_t root;
    for (int k = 0; k <= MAX_PAR; k++) g[k] = '0;
    g[0] = sym_t'(1);
    for (int i = 1; i <= npar; i++) begin
      root = gf_apow(i);
      for (int k = MAX_PAR; k > 0; k--) g[k] = g[k-1] ^ gf_pmul(g[k], root);
      g[0] = gf_pmul(g[0], root);
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_gf_mul.sv
module rs_gf_mul
  import rs_gf_pkg::*;
(
  input  sym_t a_i,
  input  sym_t b_i,
  output sym_t p_o
);
  localparam int TAB_N = 1 << SYM_W;

  sym_t exp_tab [TAB_N];
  sym_t log_tab [TAB_N];

  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    assign exp_tab[k] = gf_apow(k);
    assign log_tab[k] = gf_log(sym_t'(k));
  end

  exp_sum_t sum_raw;
  sym_t     sum_mod;

  always_comb begin
    sum_raw = {1'b0, log_tab[a_i]} + {1'b0, log_tab[b_i]};
    sum_mod = (sum_raw >= exp_sum_t'(FIELD_ORD)) ? sym_t'(sum_raw - exp_sum_t'(FIELD_ORD))
                                                 : sym_t'(sum_raw);
    p_o = (a_i == '0 || b_i == '0) ? '0 : exp_tab[sum_mod];
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_gf_pkg::*;
#(
  parameter int NPAR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic fb_en_i,
  input  sym_t din_i,
  output sym_t par_o
);
  sym_t par_q [NPAR];
  sym_t par_d [NPAR];
  sym_t prod  [NPAR];
  sym_t fb;

  // feedback gated off while parity drains
  assign fb = fb_en_i ? (din_i ^ par_q[NPAR-1]) : '0;

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    localparam sym_t COEF = gen_coef(NPAR, i);
    rs_gf_mul u_mul (.a_i(fb), .b_i(COEF), .p_o(prod[i]));
    if (i == 0) begin : g_head
      assign par_d[i] = prod[i];
    end else begin : g_body
      assign par_d[i] = par_q[i-1] ^ prod[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
    end else if (step_i) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= par_d[i];
    end
  end

  assign par_o = par_q[NPAR-1];
endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl #(
  parameter int N_SYM = 63,
  parameter int K_SYM = 55
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic ready_o,
  output logic par_phase_o,
  output logic step_o,
  output logic accept_o,
  output logic first_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(N_SYM);

  logic [CNT_W-1:0] cnt_q;

  assign par_phase_o = cnt_q >= CNT_W'(K_SYM);
  assign ready_o     = !par_phase_o;
  assign accept_o    = in_valid_i && ready_o;
  assign step_o      = accept_o || par_phase_o;
  assign first_o     = cnt_q == '0;
  assign last_o      = cnt_q == CNT_W'(N_SYM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rs_gf64_encoder.sv
module rs_gf64_encoder #(
  parameter int N_SYM = 63,
  parameter int K_SYM = 55
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  input  logic [rs_gf_pkg::SYM_W-1:0]  in_data_i,
  output logic                         in_ready_o,
  output logic                         out_valid_o,
  output logic [rs_gf_pkg::SYM_W-1:0]  out_data_o,
  output logic                         out_sof_o,
  output logic                         out_eof_o
);
  import rs_gf_pkg::*;

  localparam int NPAR = N_SYM - K_SYM;

  logic par_phase, step, accept, first, last;
  sym_t par_sym;

  rs_seq_ctrl #(.N_SYM(N_SYM), .K_SYM(K_SYM)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .ready_o     (in_ready_o),
    .par_phase_o (par_phase),
    .step_o      (step),
    .accept_o    (accept),
    .first_o     (first),
    .last_o      (last)
  );

  rs_parity_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .fb_en_i (!par_phase),
    .din_i   (in_data_i),
    .par_o   (par_sym)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else begin
      out_valid_o <= step;
      if (step) out_data_o <= par_phase ? par_sym : in_data_i;
      out_sof_o   <= accept && first;
      out_eof_o   <= par_phase && last;
    end
  end
endmodule

// File: rtl/rs_enc_chk.sv
module rs_enc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [5:0] in_data_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic [5:0] out_data_o,
  input logic       out_sof_o,
  input logic       out_eof_o
);
  // R3
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (out_valid_o && out_data_o == $past(in_data_i)));

  // R4
  parity_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o);

  // R6
  flag_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_sof_o && out_eof_o));

  // R6
  flag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sof_o || out_eof_o) |-> out_valid_o);

  // R6
  eof_reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eof_o |-> in_ready_o);

  // R7
  idle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && in_ready_o) |=> !out_valid_o);
endmodule

bind rs_gf64_encoder rs_enc_chk u_enc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_sof_o   (out_sof_o),
  .out_eof_o   (out_eof_o)
);

// File: tb/tb_rs_gf64_encoder.sv
`timescale 1ns/1ps
module tb_rs_gf64_encoder;
  localparam int N  = 63;
  localparam int K  = 55;
  localparam int NP = N - K;

  // {a, b, expected product}
  localparam logic [17:0] MUL_VEC [8] = '{
    {6'h20, 6'h02, 6'h03}, {6'h21, 6'h02, 6'h01}, {6'h20, 6'h20, 6'h30},
    {6'h21, 6'h21, 6'h31}, {6'h03, 6'h03, 6'h05}, {6'h3F, 6'h01, 6'h3F},
    {6'h00, 6'h15, 6'h00}, {6'h15, 6'h00, 6'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [5:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic [5:0] out_data;
  logic [5:0] ma = '0, mb = '0, mp;

  always #2.5 clk = ~clk;

  rs_gf64_encoder #(.N_SYM(N), .K_SYM(K)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof)
  );

  rs_gf_mul u_mul (.a_i(ma), .b_i(mb), .p_o(mp));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] t_dbl(logic [5:0] v);
    logic [5:0] r;
    r = v << 1;
    if (v[5]) r = r ^ 6'b000011;
    return r;
  endfunction

  function automatic logic [5:0] t_mul(logic [5:0] a, logic [5:0] b);
    logic [5:0] acc = '0;
    for (int k = 5; k >= 0; k--) begin
      acc = t_dbl(acc);
      if (b[k]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [5:0] t_pow(int e);
    logic [5:0] v = 6'h01;
    for (int k = 0; k < e; k++) v = t_dbl(v);
    return v;
  endfunction

  function automatic logic [5:0] msg_sym(int pat, int j);
    case (pat)
      0:       return 6'h00;
      1:       return 6'((j + 1) % 64);
      2:       return 6'((j * 37 + 11) % 64);
      default: return (j == K - 1) ? 6'h3F : 6'h00;
    endcase
  endfunction

  // output monitor
  logic [5:0] cw [N];
  int stamp [N];
  int widx = 0, done_cnt = 0, flag_err = 0, cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) widx = 0;
    else if (out_valid) begin
      if (out_sof != (widx == 0))     flag_err++;
      if (out_eof != (widx == N - 1)) flag_err++;
      cw[widx] = out_data;
      stamp[widx] = cyc;
      widx++;
      if (widx == N) begin
        widx = 0;
        done_cnt++;
      end
    end else if (out_sof || out_eof) flag_err++;
  end

  function automatic bit syn_zero();
    logic [5:0] s, r;
    for (int i = 1; i <= NP; i++) begin
      r = t_pow(i);
      s = '0;
      for (int j = 0; j < N; j++) s = t_mul(s, r) ^ cw[j];
      if (s != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic run_cw(input int pat, input bit gaps);
    int base, j, n, bad, hole;
    bit acc, v;
    base = done_cnt;
    j = 0;
    n = 0;
    flag_err = 0;
    while (j < K) begin
      v = gaps ? (n % 3 != 1) : 1'b1;
      in_valid = v;
      in_data = msg_sym(pat, j);
      acc = v && in_ready;
      @(posedge clk); #1;
      n++;
      if (acc) j++;
    end
    in_valid = 1'b1; // offered during parity, must be ignored
    in_data = 6'h2A;
    repeat (NP) @(posedge clk);
    #1 in_valid = 1'b0;
    while (done_cnt == base) @(posedge clk);
    #1;
    bad = 0;
    for (int k = 0; k < K; k++) if (cw[k] != msg_sym(pat, k)) bad++;
    check(bad == 0, gaps ? "R3 R7 data copy with gaps" : "R3 data copy", bad, 0);
    hole = 0;
    for (int k = K; k < N; k++) if (stamp[k] != stamp[k-1] + 1) hole++;
    check(hole == 0, "R4 parity contiguous", hole, 0);
    check(flag_err == 0, "R6 sof/eof markers", flag_err, 0);
    check(syn_zero(), "R5 syndromes zero", 0, 0);
    cw[(pat * 13 + 5) % N] ^= 6'h15;
    check(!syn_zero(), "R9 corrupted symbol detected", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    // R1 R2 vector table
    for (int i = 0; i < 8; i++) begin
      ma = MUL_VEC[i][17:12];
      mb = MUL_VEC[i][11:6];
      #1;
      check(mp == MUL_VEC[i][5:0], "R1 R2 product vector", mp, MUL_VEC[i][5:0]);
    end
    bad = 0;
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 64; b++) begin
        ma = 6'(a);
        mb = 6'(b);
        #1;
        if (mp != t_mul(6'(a), 6'(b))) bad++;
      end
    check(bad == 0, "R1 exhaustive product", bad, 0);

    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && in_ready && !out_sof && !out_eof, "R8 reset state",
          {out_valid, in_ready, out_sof, out_eof}, 4'b0100);
    rst_n = 1'b1;
    @(posedge clk); #1;

    run_cw(0, 1'b0);
    run_cw(1, 1'b0);
    run_cw(2, 1'b1);
    run_cw(3, 1'b0);

    // R8 reset mid-codeword
    in_valid = 1'b1;
    for (int k = 0; k < 10; k++) begin
      in_data = 6'(k + 7);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    #3;
    check(!out_valid && in_ready && !out_sof && !out_eof, "R8 mid-codeword reset",
          {out_valid, in_ready, out_sof, out_eof}, 4'b0100);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    run_cw(2, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule